// File: doc/BRIEF.md
# Infrared Receiver Run-Length Sampler

This block takes one demodulated infrared receiver line and measures how long it stays at each level. The line is sampled on a tick derived from the module clock by a fixed divider. Each stretch of constant level becomes one byte that carries the level and the length of the stretch in samples. The bytes queue up in a receive FIFO that software drains through a small memory-mapped register interface.

Before it is measured, the line can be inverted, and a programmable noise filter absorbs short glitches into the run around them. A packet starts at the first pulse after idle. It ends once the line has stayed inactive for a programmable number of 128-sample blocks. At that point the last run is flushed and a packet-end flag is raised. Pending flags for overflow, packet end and FIFO level drive one interrupt line through per-flag enables. Protocol decoding is left to software.

Top module: `irrx_sampler`

## Requirements
- R1: The line is sampled once every PRESCALE clock cycles (default 64). A level held for N·PRESCALE cycles is reported as a run of N samples.
- R2: A FIFO byte holds the level in bit 7 (1 = pulse) and the run length minus one in bits 6:0.
- R3: When bit 2 of the receive-configuration register (address 0x04) is 1, the input is inverted before sampling.
- R4: A level change that lasts no more than the noise threshold (bits 7:2 of the sample-configuration register, address 0x08) in samples is merged into the surrounding run. The lengths of longer runs are kept.
- R5: A run longer than 128 samples is emitted as bytes of length 128 (0xFF for a pulse, 0x7F for a space), followed by a byte for the remainder.
- R6: Idle before the first pulse is not recorded. Once a packet is open, after idle-threshold × 128 inactive samples (idle threshold in bits 15:8 of address 0x08) the pending run is flushed and status bit 1 (packet end) is set.
- R7: Reception runs only when control register (0x00) bit 0 and bit 1 are both 1 and bits 5:4 equal 2'b11. Otherwise the divider, the run logic and the FIFO are held cleared.
- R8: Reading the data register (0x14) returns the oldest byte and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R9: A byte pushed into a full FIFO is dropped and status bit 0 (overflow) is set.
- R10: The status register (0x10) shows the pending flags in bits 7:0, which are cleared by writing 1 to them, and the FIFO occupancy from bit 8 up.
- R11: Status bit 4 (data available) is pending whenever the occupancy is nonzero and at least the trigger level in bits 8 and up of the interrupt-enable register (0x0C).
- R12: irq is high exactly when a pending flag is set whose enable is set in bits 0, 1 or 4 of register 0x0C.
- R13: After reset every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated receiver line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data register) |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational and valid in the cycle of the strobe, so the bench samples it a little after the driving edge. The FIFO pop it causes takes effect at the next rising edge, and status flags and irq follow their cause by one clock. A byte appears about five clocks after the sample that closes its run: two for input synchronization, one for the tick, one for the filter and one for the encoder. The bench therefore holds every level for whole multiples of PRESCALE cycles. It then waits the full idle window plus a margin before it reads status and drains the FIFO. That makes the expected byte lists depend only on sample counts and not on the phase of the divider.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

    localparam int REG_W = 16;

    localparam logic [4:0] ADR_CTRL  = 5'h00;
    localparam logic [4:0] ADR_RXCFG = 5'h04;
    localparam logic [4:0] ADR_SAMP  = 5'h08;
    localparam logic [4:0] ADR_IEN   = 5'h0C;
    localparam logic [4:0] ADR_STAT  = 5'h10;
    localparam logic [4:0] ADR_DATA  = 5'h14;

    localparam int         RUN_MAX = 128;
    localparam logic [1:0] MODE_RX = 2'b11;

    typedef struct packed {
        logic       pulse;
        logic [6:0] len_m1;
    } run_byte_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       rxen;
        logic       gen;
    } ctrl_t;

    typedef struct packed {
        logic [7:0] idle_thr;
        logic [5:0] noise_thr;
    } samp_cfg_t;

    typedef enum logic {ENC_WAIT, ENC_PKT} enc_state_t;

    function automatic run_byte_t pack_run(input logic lvl, input logic [7:0] cnt);
        run_byte_t b;
        b.pulse  = lvl;
        b.len_m1 = 7'(cnt - 8'd1);
        return b;
    endfunction

endpackage

// File: rtl/irrx_prescale.sv
module irrx_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/irrx_filter.sv
module irrx_filter #(
    parameter int NW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          smp,
    input  logic [NW-1:0] noise_thr,
    output logic          lvl,
    output logic          vld
);
    // A new level is accepted only after noise_thr+1 consecutive differing
    // samples; every edge is delayed by the same amount, so lengths are kept.
    logic [NW-1:0] cand_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            lvl    <= 1'b0;
            vld    <= 1'b0;
            cand_q <= '0;
        end else begin
            vld <= tick;
            if (tick) begin
                if (smp == lvl) begin
                    cand_q <= '0;
                end else if (cand_q >= noise_thr) begin
                    lvl    <= smp;
                    cand_q <= '0;
                end else begin
                    cand_q <= cand_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irrx_runenc.sv
module irrx_runenc
    import irrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      vld,
    input  logic      lvl,
    input  logic [7:0] idle_thr,
    output logic      push,
    output run_byte_t byte_o,
    output logic      pkt_end
);
    enc_state_t  st_q;
    logic        run_lvl_q;
    logic [7:0]  run_cnt_q;
    logic [15:0] idle_q;
    logic [15:0] idle_n;
    logic [15:0] idle_lim;

    assign idle_lim = {1'b0, idle_thr, 7'd0} + 16'd1;

    always_comb idle_n = lvl ? 16'd0 : idle_q + 16'd1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st_q      <= ENC_WAIT;
            run_lvl_q <= 1'b0;
            run_cnt_q <= 8'd0;
            idle_q    <= 16'd0;
            push      <= 1'b0;
            pkt_end   <= 1'b0;
            byte_o    <= '0;
        end else begin
            push    <= 1'b0;
            pkt_end <= 1'b0;
            if (vld) begin
                if (st_q == ENC_WAIT) begin
                    if (lvl) begin
                        st_q      <= ENC_PKT;
                        run_lvl_q <= 1'b1;
                        run_cnt_q <= 8'd1;
                        idle_q    <= 16'd0;
                    end
                end else begin
                    idle_q <= idle_n;
                    if (!lvl && idle_n == idle_lim) begin
                        push    <= 1'b1;
                        byte_o  <= pack_run(run_lvl_q, run_cnt_q);
                        pkt_end <= 1'b1;
                        st_q    <= ENC_WAIT;
                        idle_q  <= 16'd0;
                    end else if (lvl == run_lvl_q) begin
                        if (run_cnt_q == 8'(RUN_MAX)) begin
                            push      <= 1'b1;
                            byte_o    <= pack_run(run_lvl_q, run_cnt_q);
                            run_cnt_q <= 8'd1;
                        end else begin
                            run_cnt_q <= run_cnt_q + 8'd1;
                        end
                    end else begin
                        push      <= 1'b1;
                        byte_o    <= pack_run(run_lvl_q, run_cnt_q);
                        run_lvl_q <= lvl;
                        run_cnt_q <= 8'd1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic          full;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign ovf     = push && full;
    assign dout    = (count == '0) ? 8'h00 : mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/irrx_sampler.sv
module irrx_sampler
    import irrx_pkg::*;
#(
    parameter  int PRESCALE   = 64,
    parameter  int FIFO_DEPTH = 16,
    localparam int CW         = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ir_in,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [4:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    ctrl_t       ctrl_q;
    logic        inv_q;
    samp_cfg_t   samp_q;
    logic        ien_ovf_q, ien_end_q, ien_av_q;
    logic [CW-1:0] trig_q;
    logic [7:0]  pend_q;
    logic [7:0]  pend_set, pend_clr, irq_mask;

    logic        en;
    logic        sync1_q, sync2_q;
    logic        tick, f_lvl, f_vld;
    logic        enc_push, pkt_end, fifo_ovf, data_rd;
    run_byte_t   enc_byte;
    logic [7:0]  fifo_dout;
    logic [CW-1:0] fifo_cnt;

    assign en      = ctrl_q.gen && ctrl_q.rxen && (ctrl_q.mode == MODE_RX);
    assign data_rd = reg_rd && (reg_addr == ADR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ir_in;
            sync2_q <= sync1_q;
        end
    end

    irrx_prescale #(.DIV(PRESCALE)) u_div (
        .clk(clk), .rst(rst), .run(en), .tick(tick)
    );

    irrx_filter #(.NW(6)) u_filt (
        .clk(clk), .rst(rst), .run(en), .tick(tick),
        .smp(sync2_q ^ inv_q), .noise_thr(samp_q.noise_thr),
        .lvl(f_lvl), .vld(f_vld)
    );

    irrx_runenc u_enc (
        .clk(clk), .rst(rst), .run(en), .vld(f_vld), .lvl(f_lvl),
        .idle_thr(samp_q.idle_thr), .push(enc_push), .byte_o(enc_byte),
        .pkt_end(pkt_end)
    );

    irrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(!en), .push(enc_push), .din(enc_byte),
        .pop(data_rd), .dout(fifo_dout), .count(fifo_cnt), .ovf(fifo_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            inv_q     <= 1'b0;
            samp_q    <= '0;
            ien_ovf_q <= 1'b0;
            ien_end_q <= 1'b0;
            ien_av_q  <= 1'b0;
            trig_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL: begin
                    ctrl_q.gen  <= reg_wdata[0];
                    ctrl_q.rxen <= reg_wdata[1];
                    ctrl_q.mode <= reg_wdata[5:4];
                end
                ADR_RXCFG: inv_q <= reg_wdata[2];
                ADR_SAMP: begin
                    samp_q.noise_thr <= reg_wdata[7:2];
                    samp_q.idle_thr  <= reg_wdata[15:8];
                end
                ADR_IEN: begin
                    ien_ovf_q <= reg_wdata[0];
                    ien_end_q <= reg_wdata[1];
                    ien_av_q  <= reg_wdata[4];
                    trig_q    <= reg_wdata[8 +: CW];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        pend_set    = 8'h00;
        pend_set[0] = fifo_ovf;
        pend_set[1] = pkt_end;
        pend_set[4] = (fifo_cnt != '0) && (fifo_cnt >= trig_q);
        pend_clr    = (reg_wr && reg_addr == ADR_STAT) ? reg_wdata[7:0] : 8'h00;
        irq_mask    = {3'b000, ien_av_q, 2'b00, ien_end_q, ien_ovf_q};
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 8'h00;
        else     pend_q <= ((pend_q & ~pend_clr) | pend_set) & 8'h13;
    end

    assign irq = |(pend_q & irq_mask);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[0]   = ctrl_q.gen;
                reg_rdata[1]   = ctrl_q.rxen;
                reg_rdata[5:4] = ctrl_q.mode;
            end
            ADR_RXCFG: reg_rdata[2] = inv_q;
            ADR_SAMP: begin
                reg_rdata[7:2]  = samp_q.noise_thr;
                reg_rdata[15:8] = samp_q.idle_thr;
            end
            ADR_IEN: begin
                reg_rdata[7:0]    = irq_mask;
                reg_rdata[8 +: CW] = trig_q;
            end
            ADR_STAT: begin
                reg_rdata[7:0]     = pend_q;
                reg_rdata[8 +: CW] = fifo_cnt;
            end
            ADR_DATA: reg_rdata[7:0] = fifo_dout;
            default: ;
        endcase
    end
endmodule

// File: rtl/irrx_sampler_chk.sv
module irrx_sampler_chk #(
    parameter  int FIFO_DEPTH = 16,
    localparam int CW         = $clog2(FIFO_DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          tick,
    input logic          enc_push,
    input logic          pkt_end,
    input logic          data_rd,
    input logic [CW-1:0] fifo_cnt,
    input logic [7:0]    pend_q,
    input logic [15:0]   reg_rdata,
    input logic [7:0]    irq_mask,
    input logic          irq
);
    AST_PUSH_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
        enc_push |-> $past(tick, 2)); // R1

    AST_PKT_END_FLAG: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> pend_q[1]); // R6

    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (fifo_cnt == '0)); // R7

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (data_rd && fifo_cnt == '0) |-> (reg_rdata == 16'h0000)); // R8

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (data_rd && fifo_cnt == '0 && !enc_push && en) |=> (fifo_cnt == '0)); // R8

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (enc_push && fifo_cnt == CW'(FIFO_DEPTH) && !data_rd && en)
        |=> (fifo_cnt == CW'(FIFO_DEPTH)) && pend_q[0]); // R9

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == 8'h00) |-> !irq); // R12
endmodule

bind irrx_sampler irrx_sampler_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .enc_push(enc_push),
    .pkt_end(pkt_end), .data_rd(data_rd), .fifo_cnt(fifo_cnt),
    .pend_q(pend_q), .reg_rdata(reg_rdata), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/irrx_sampler_tb_top.sv
module irrx_sampler_tb_top;
    localparam int P = 4;
    localparam int D = 16;

    localparam logic [4:0] A_CTRL = 5'h00, A_RXCFG = 5'h04, A_SAMP = 5'h08,
                           A_IEN = 5'h0C, A_STAT = 5'h10, A_DATA = 5'h14;

    // {frame, level, samples}
    localparam logic [12:0] SEG [11] = '{
        {2'd0, 1'b1, 10'd5},  {2'd0, 1'b0, 10'd3},  {2'd0, 1'b1, 10'd200},
        {2'd1, 1'b1, 10'd10}, {2'd1, 1'b0, 10'd2},  {2'd1, 1'b1, 10'd10},
        {2'd1, 1'b0, 10'd5},  {2'd1, 1'b1, 10'd3},
        {2'd2, 1'b1, 10'd6},  {2'd2, 1'b0, 10'd4},  {2'd2, 1'b1, 10'd2}
    };
    // {frame, expected byte}
    localparam logic [9:0] EXP [13] = '{
        {2'd0, 8'h84}, {2'd0, 8'h02}, {2'd0, 8'hFF}, {2'd0, 8'hC7}, {2'd0, 8'h7F},
        {2'd1, 8'h95}, {2'd1, 8'h04}, {2'd1, 8'h82}, {2'd1, 8'h7F},
        {2'd2, 8'h85}, {2'd2, 8'h03}, {2'd2, 8'h81}, {2'd2, 8'h7F}
    };
    // {noise threshold, invert}
    localparam logic [6:0] CFG [3] = '{ {6'd0, 1'b0}, {6'd2, 1'b0}, {6'd0, 1'b1} };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irrx_sampler #(.PRESCALE(P), .FIFO_DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hold(input logic lv, input int n);
        ir_in = lv;
        repeat (n * P) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R13 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        rd(A_CTRL, v); check("R13 ctrl after reset", v, 0);
        rd(A_STAT, v); check("R13 status after reset", v, 0);
        check("R13 irq after reset", irq, 0);

        // table-driven frames: R1 R2 R5 (frame 0), R4 (frame 1), R3 (frame 2), R6
        for (int f = 0; f < 3; f++) begin
            logic inv;
            int   ne;
            int   k;
            string tg;
            inv = CFG[f][0];
            tg  = (f == 0) ? "R1/R2/R5" : ((f == 1) ? "R4" : "R3");
            wr(A_CTRL, 16'h0000);
            wr(A_RXCFG, {13'd0, inv, 2'b00});
            wr(A_SAMP, {8'd1, CFG[f][6:1], 2'b00});
            ir_in = inv;
            repeat (5) @(negedge clk);
            wr(A_CTRL, 16'h0033);
            wr(A_STAT, 16'h00FF);
            repeat (10 * P) @(negedge clk);
            for (int s = 0; s < 11; s++)
                if (SEG[s][12:11] == f[1:0]) hold(SEG[s][10] ^ inv, int'(SEG[s][9:0]));
            ir_in = inv;
            repeat ((128 + 20) * P) @(negedge clk);
            ne = 0;
            for (int e = 0; e < 13; e++) if (EXP[e][9:8] == f[1:0]) ne++;
            rd(A_STAT, v);
            check({tg, " R10 occupancy"}, v[12:8], ne);
            check("R6 packet end flag", v[1], 1);
            k = 0;
            for (int e = 0; e < 13; e++) begin
                if (EXP[e][9:8] == f[1:0]) begin
                    rd(A_DATA, v);
                    check({tg, " byte"}, v[7:0], EXP[e][7:0]);
                    k++;
                end
            end
        end

        // R8 empty read returns zero and leaves occupancy at zero
        rd(A_DATA, v); check("R8 empty read", v, 0);
        rd(A_STAT, v); check("R8 occupancy after empty read", v[12:8], 0);

        // R9 R10 R11 R12 overflow and trigger level
        wr(A_CTRL, 16'h0000);
        wr(A_RXCFG, 16'h0000);
        wr(A_SAMP, 16'h0100);
        ir_in = 1'b0;
        repeat (5) @(negedge clk);
        wr(A_CTRL, 16'h0033);
        wr(A_STAT, 16'h00FF);
        wr(A_IEN, 16'h0801);
        hold(1'b1, 20 * 128);
        ir_in = 1'b0;
        repeat (150 * P) @(negedge clk);
        rd(A_STAT, v);
        check("R9 occupancy full", v[12:8], D);
        check("R9 R11 pending flags", v[7:0], 8'h13);
        check("R12 irq on overflow", irq, 1);
        wr(A_STAT, 16'h00FF);
        rd(A_STAT, v);
        check("R10 R11 clear keeps level flag", v[7:0], 8'h10);
        check("R12 irq after clear", irq, 0);
        rd(A_DATA, v); check("R9 oldest byte kept", v[7:0], 8'hFF);
        for (int i = 0; i < 8; i++) rd(A_DATA, v);
        rd(A_STAT, v);
        check("R8 pops reduce occupancy", v[12:8], 7);
        wr(A_STAT, 16'h0010);
        rd(A_STAT, v);
        check("R11 below level no flag", v[7:0], 8'h00);
        wr(A_IEN, 16'h0410);
        @(negedge clk);
        check("R11 R12 level irq", irq, 1);
        rd(A_STAT, v); check("R11 flag at level", v[4], 1);

        // R7 mode field must be 2'b11
        wr(A_CTRL, 16'h0003);
        rd(A_STAT, v); check("R7 bad mode clears FIFO", v[12:8], 0);
        wr(A_CTRL, 16'h0013);
        hold(1'b1, 10);
        ir_in = 1'b0;
        repeat (140 * P) @(negedge clk);
        rd(A_STAT, v); check("R7 no capture when off", v[12:8], 0);
        check("R7 no packet end when off", v[1], 0);

        finish_run();
    end
endmodule